// File: doc/BRIEF.md
# Reset and Sleep Status Controller

This block decides when the core may run, when it is held in reset and when it sleeps. It watches a power-on indication, an active-low external reset pin and a watchdog time-out. It also takes two one-cycle commands from the core: enter sleep, and clear the watchdog. From these it keeps a three-state sequence: reset hold, run and sleep. It also keeps two sticky status flags. The time-out flag sits at status bit 4 and the power-down flag at status bit 3. Each kind of reset or wake-up event writes these two flags with its own rule, so software can tell after a restart what happened.

After power-on, the internal reset stays asserted for a programmable number of base ticks. Only ticks seen while the external reset pin is high are counted. The same hold follows every external reset and every watchdog time-out. Sleep drops the core-run output. A watchdog time-out or an external reset then wakes the device through a fresh reset hold. A 3-bit reset-cause code names the last reset event. It reads 0 while the reset hold lasts.

Top module: `rst_sleep_ctrl`

## Requirements
- R1: While `porActive` is high, `coreRst` is 1 and `coreRun` is 0 at once, without waiting for a clock. `statusView` reads 8'h18 (bit 4 time-out = 1, bit 3 power-down = 1, all other bits 0), and `wdtClearOut` is 0. After the hold ends, `resetCause` reads 1 (power-on).
- R2: Once `porActive` falls, `coreRst` stays 1 until `HOLD_TICKS` clock edges have sampled `tick`=1 with `extRstN`=1. A sampled `extRstN`=0 restarts that count from zero. `coreRst` falls, and `coreRun` rises, on the edge that samples the last of those ticks.
- R3: `wdtClearCmd` while running sets both flags to 1. It drives `wdtClearOut` high for exactly the one cycle after the edge that sampled it.
- R4: `sleepCmd` while running sets `asleep`=1 and `coreRun`=0, makes time-out 1 and power-down 0, and pulses `wdtClearOut` for one cycle.
- R5: `extRstN`=0 while running leaves both flags unchanged and enters the reset hold. After the hold, `resetCause` reads 2.
- R6: `extRstN`=0 while asleep makes time-out 1 and power-down 0. It wakes the device through the reset hold, and afterwards `resetCause` reads 3.
- R7: `wdtExpire` while running makes time-out 0 and power-down 1 and enters the reset hold. Afterwards `resetCause` reads 4.
- R8: `wdtExpire` while asleep makes both flags 0 and wakes the device through the reset hold. Afterwards `resetCause` reads 5.
- R9: When several inputs are active in one cycle, `porActive` wins over `extRstN`=0, which wins over `wdtExpire`, which wins over `sleepCmd`, which wins over `wdtClearCmd`.
- R10: During the reset hold, `wdtExpire`, `sleepCmd` and `wdtClearCmd` have no effect on the flags, the hold count or `wdtClearOut`. While asleep, `sleepCmd` and `wdtClearCmd` have no effect.
- R11: `resetCause` reads 0 while `coreRst` is 1. It keeps the last reset's code through run and sleep; entering sleep does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porActive | input | 1 | Power-on indication, high while supply is not yet valid (asynchronous) |
| extRstN | input | 1 | External reset pin, active low, synchronous sample |
| wdtExpire | input | 1 | Watchdog time-out pulse |
| sleepCmd | input | 1 | Enter-sleep command pulse from the core |
| wdtClearCmd | input | 1 | Watchdog-clear command pulse from the core |
| tick | input | 1 | Base tick enable for timing the reset hold |
| coreRst | output | 1 | Internal reset to the core |
| coreRun | output | 1 | Core may execute (not in reset, not asleep) |
| asleep | output | 1 | Device is in sleep |
| wdtClearOut | output | 1 | One-cycle strobe clearing the watchdog counter |
| statusView | output | 8 | Status byte: bit 4 time-out flag, bit 3 power-down flag, others 0 |
| resetCause | output | 3 | 0 during hold; 1 power-on, 2 external in run, 3 external in sleep, 4 watchdog in run, 5 watchdog in sleep |

## Verification
The bench builds the block with `HOLD_TICKS` = 3, so every reset hold finishes within a few cycles. This lets one run walk through every event kind, each wake-up from sleep and each priority collision. During power-on release, `tick` is first held low and then `extRstN` is pulsed low part-way through the count. This shows that the hold counts only qualified ticks and restarts on the pin. A second power-on, raised in the middle of a run together with an external reset and a watchdog time-out, shows the asynchronous take-over and that the power-on cause wins.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SLEEP = 2'd2
  } seqState_t;

  // one-hot strobes from sequencer to flag datapath
  typedef struct packed {
    logic evtExtRun;
    logic evtExtSleep;
    logic evtWdtRun;
    logic evtWdtSleep;
    logic evtSleep;
    logic evtClear;
  } evtStrobe_t;

  localparam int STATUS_W = 8;
  localparam int TO_BIT   = 4;
  localparam int PD_BIT   = 3;
  localparam int CAUSE_W  = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE      = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_POR       = 3'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_EXT_RUN   = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_EXT_SLEEP = 3'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_WDT_RUN   = 3'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_WDT_SLEEP = 3'd5;

endpackage

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int HOLD_TICKS = 18
) (
  input  logic       clk,
  input  logic       porActive,
  input  logic       extRstN,
  input  logic       wdtExpire,
  input  logic       sleepCmd,
  input  logic       wdtClearCmd,
  input  logic       tick,
  output evtStrobe_t evt,
  output logic       coreRst,
  output logic       coreRun,
  output logic       asleep
);

  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_TICKS - 1);

  seqState_t        state, nextState;
  logic [CNT_W-1:0] holdCnt, nextCnt;

  always_comb begin
    evt       = '0;
    nextState = state;
    nextCnt   = holdCnt;
    if (!extRstN) begin
      // external reset outranks every other event
      evt.evtExtRun   = (state == ST_RUN);
      evt.evtExtSleep = (state == ST_SLEEP);
      nextState = ST_HOLD;
      nextCnt   = '0;
    end else if (wdtExpire && state != ST_HOLD) begin
      evt.evtWdtRun   = (state == ST_RUN);
      evt.evtWdtSleep = (state == ST_SLEEP);
      nextState = ST_HOLD;
      nextCnt   = '0;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (tick) begin
            if (holdCnt == LAST_CNT) begin
              nextState = ST_RUN;
              nextCnt   = '0;
            end else begin
              nextCnt = holdCnt + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (sleepCmd) begin
            evt.evtSleep = 1'b1;
            nextState    = ST_SLEEP;
          end else if (wdtClearCmd) begin
            evt.evtClear = 1'b1;
          end
        end
        ST_SLEEP: ;
        default: nextState = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) begin
      state   <= ST_HOLD;
      holdCnt <= '0;
    end else begin
      state   <= nextState;
      holdCnt <= nextCnt;
    end
  end

  assign coreRst = (state == ST_HOLD);
  assign coreRun = (state == ST_RUN);
  assign asleep  = (state == ST_SLEEP);

  // R5: a low reset pin always lands in the reset hold
  p_ext_enters_hold_r5: assert property (@(posedge clk) disable iff (porActive)
    !extRstN |=> coreRst);

  // R2: leaving the hold needs a qualified tick
  p_release_needs_tick_r2: assert property (@(posedge clk) disable iff (porActive)
    $fell(coreRst) |-> ($past(tick) && $past(extRstN)));

  // R4: sleep drops the run output
  p_sleep_stops_run_r4: assert property (@(posedge clk) disable iff (porActive)
    (coreRun && sleepCmd && extRstN && !wdtExpire) |=> (asleep && !coreRun));

  // R8: watchdog wakes a sleeping device into the hold
  p_wdt_wakes_r8: assert property (@(posedge clk) disable iff (porActive)
    (asleep && wdtExpire && extRstN) |=> coreRst);

endmodule

// File: rtl/rsc_flags.sv
module rsc_flags
  import rsc_pkg::*;
(
  input  logic                clk,
  input  logic                porActive,
  input  evtStrobe_t          evt,
  input  logic                coreRst,
  output logic [STATUS_W-1:0] statusView,
  output logic [CAUSE_W-1:0]  resetCause,
  output logic                wdtClearOut
);

  logic               flagTo, flagPd;
  logic [CAUSE_W-1:0] causeQ;

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) begin
      flagTo      <= 1'b1;
      flagPd      <= 1'b1;
      causeQ      <= CAUSE_POR;
      wdtClearOut <= 1'b0;
    end else begin
      wdtClearOut <= evt.evtSleep | evt.evtClear;
      if (evt.evtExtRun) begin
        causeQ <= CAUSE_EXT_RUN;
      end else if (evt.evtExtSleep) begin
        flagTo <= 1'b1;
        flagPd <= 1'b0;
        causeQ <= CAUSE_EXT_SLEEP;
      end else if (evt.evtWdtRun) begin
        flagTo <= 1'b0;
        flagPd <= 1'b1;
        causeQ <= CAUSE_WDT_RUN;
      end else if (evt.evtWdtSleep) begin
        flagTo <= 1'b0;
        flagPd <= 1'b0;
        causeQ <= CAUSE_WDT_SLEEP;
      end else if (evt.evtSleep) begin
        flagTo <= 1'b1;
        flagPd <= 1'b0;
      end else if (evt.evtClear) begin
        flagTo <= 1'b1;
        flagPd <= 1'b1;
      end
    end
  end

  for (genvar b = 0; b < STATUS_W; b++) begin : g_status
    if (b == TO_BIT) begin : g_to
      assign statusView[b] = flagTo;
    end else if (b == PD_BIT) begin : g_pd
      assign statusView[b] = flagPd;
    end else begin : g_zero
      assign statusView[b] = 1'b0;
    end
  end

  assign resetCause = coreRst ? CAUSE_NONE : causeQ;

  // R3: clear command sets both flags
  p_clear_sets_r3: assert property (@(posedge clk) disable iff (porActive)
    evt.evtClear |=> (flagTo && flagPd));

  // R4: sleep entry flag pattern
  p_sleep_flags_r4: assert property (@(posedge clk) disable iff (porActive)
    evt.evtSleep |=> (flagTo && !flagPd));

  // R5: external reset in run keeps the flags
  p_ext_run_keeps_r5: assert property (@(posedge clk) disable iff (porActive)
    evt.evtExtRun |=> ($stable(flagTo) && $stable(flagPd)));

  // R8: watchdog in sleep clears both flags
  p_wdt_sleep_r8: assert property (@(posedge clk) disable iff (porActive)
    evt.evtWdtSleep |=> (!flagTo && !flagPd));

  // R9: at most one event per cycle
  p_one_event_r9: assert property (@(posedge clk) disable iff (porActive)
    $onehot0(evt));

endmodule

// File: rtl/rst_sleep_ctrl.sv
module rst_sleep_ctrl
  import rsc_pkg::*;
#(
  parameter int HOLD_TICKS = 18
) (
  input  logic                clk,
  input  logic                porActive,
  input  logic                extRstN,
  input  logic                wdtExpire,
  input  logic                sleepCmd,
  input  logic                wdtClearCmd,
  input  logic                tick,
  output logic                coreRst,
  output logic                coreRun,
  output logic                asleep,
  output logic                wdtClearOut,
  output logic [STATUS_W-1:0] statusView,
  output logic [CAUSE_W-1:0]  resetCause
);

  evtStrobe_t evt;

  rsc_seq #(.HOLD_TICKS(HOLD_TICKS)) u_seq (
    .clk(clk), .porActive(porActive), .extRstN(extRstN),
    .wdtExpire(wdtExpire), .sleepCmd(sleepCmd), .wdtClearCmd(wdtClearCmd),
    .tick(tick), .evt(evt), .coreRst(coreRst), .coreRun(coreRun),
    .asleep(asleep)
  );

  rsc_flags u_flags (
    .clk(clk), .porActive(porActive), .evt(evt), .coreRst(coreRst),
    .statusView(statusView), .resetCause(resetCause),
    .wdtClearOut(wdtClearOut)
  );

endmodule

// File: tb/rst_sleep_ctrl_test.sv
`timescale 1ns/1ps
module rst_sleep_ctrl_test;

  logic clk = 1'b0;
  logic porActive = 1'b1, extRstN = 1'b1, wdtExpire = 1'b0;
  logic sleepCmd = 1'b0, wdtClearCmd = 1'b0, tick = 1'b0;
  logic coreRst, coreRun, asleep, wdtClearOut;
  logic [7:0] statusView;
  logic [2:0] resetCause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_sleep_ctrl #(.HOLD_TICKS(3)) uut (
    .clk(clk), .porActive(porActive), .extRstN(extRstN), .wdtExpire(wdtExpire),
    .sleepCmd(sleepCmd), .wdtClearCmd(wdtClearCmd), .tick(tick),
    .coreRst(coreRst), .coreRun(coreRun), .asleep(asleep),
    .wdtClearOut(wdtClearOut), .statusView(statusView), .resetCause(resetCause)
  );

  // stimulus {extRstN,wdtExpire,sleepCmd,wdtClearCmd}
  // expected {coreRst,coreRun,asleep,wdtClearOut}_{to,pd}_{cause}
  localparam int NV = 32;
  localparam logic [12:0] VEC [NV] = '{
    13'b1000_0100_11_001, // 0  R3 idle run
    13'b1010_0011_10_001, // 1  R4 sleep
    13'b1000_0010_10_001, // 2  R4 stays asleep
    13'b1001_0010_10_001, // 3  R10 clear ignored asleep
    13'b1100_1000_00_000, // 4  R8 wdt in sleep
    13'b1000_1000_00_000, // 5  R8
    13'b1000_1000_00_000, // 6  R8
    13'b1000_0100_00_101, // 7  R8 cause 5
    13'b1001_0101_11_101, // 8  R3 clear
    13'b1100_1000_01_000, // 9  R7 wdt in run
    13'b1000_1000_01_000, // 10 R7
    13'b1000_1000_01_000, // 11 R7
    13'b1000_0100_01_100, // 12 R7 cause 4
    13'b0000_1000_01_000, // 13 R5 ext in run
    13'b1000_1000_01_000, // 14 R5
    13'b1000_1000_01_000, // 15 R5
    13'b1000_0100_01_010, // 16 R5 cause 2
    13'b1010_0011_10_010, // 17 R4 R11 sleep keeps cause
    13'b0000_1000_10_000, // 18 R6 ext in sleep
    13'b1000_1000_10_000, // 19 R6
    13'b1000_1000_10_000, // 20 R6
    13'b1000_0100_10_011, // 21 R6 cause 3
    13'b0111_1000_10_000, // 22 R9 ext beats all
    13'b1000_1000_10_000, // 23 R9
    13'b1000_1000_10_000, // 24 R9
    13'b1000_0100_10_010, // 25 R9 cause 2
    13'b1110_1000_01_000, // 26 R9 wdt beats sleep
    13'b1111_1000_01_000, // 27 R10 ignored in hold
    13'b1000_1000_01_000, // 28 R10
    13'b1000_0100_01_100, // 29 R10 hold count unaffected
    13'b1011_0011_10_100, // 30 R9 sleep beats clear
    13'b1001_0010_10_100  // 31 R10 clear ignored asleep
  };

  function automatic string reqOf(int i);
    if (i == 0 || i == 8) return "R3";
    if (i <= 2 || i == 17) return "R4";
    if (i == 3 || i == 31 || (i >= 27 && i <= 29)) return "R10";
    if (i <= 7) return "R8";
    if (i <= 12) return "R7";
    if (i <= 16) return "R5";
    if (i <= 21) return "R6";
    return "R9";
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rst/run", {14'd0, coreRst, coreRun}, 16'h2);
    chk("R1 status", {8'd0, statusView}, 16'h18);
    chk("R1 cause/clr", {12'd0, resetCause, wdtClearOut}, 16'h0);

    porActive = 1'b0;
    repeat (3) step();
    chk("R2 no tick", {15'd0, coreRst}, 16'h1);
    tick = 1'b1;
    step();
    extRstN = 1'b0;
    step();
    chk("R2 pin low restarts", {15'd0, coreRst}, 16'h1);
    chk("R11 cause in hold", {13'd0, resetCause}, 16'h0);
    extRstN = 1'b1;
    step();
    step();
    chk("R2 not yet", {15'd0, coreRst}, 16'h1);
    step();
    chk("R2 released", {14'd0, coreRst, coreRun}, 16'h1);
    chk("R1 por cause", {13'd0, resetCause}, 16'h1);
    chk("R1 flags", {8'd0, statusView}, 16'h18);

    for (int i = 0; i < NV; i++) begin
      extRstN     = VEC[i][12];
      wdtExpire   = VEC[i][11];
      sleepCmd    = VEC[i][10];
      wdtClearCmd = VEC[i][9];
      step();
      chk($sformatf("%s vec%0d", reqOf(i), i),
          {7'd0, coreRst, coreRun, asleep, wdtClearOut,
           statusView[4], statusView[3], resetCause},
          {7'd0, VEC[i][8:0]});
      chk($sformatf("%s vec%0d other bits", reqOf(i), i),
          {8'd0, statusView & 8'hE7}, 16'h0);
    end
    extRstN = 1'b1; wdtExpire = 1'b0; sleepCmd = 1'b0; wdtClearCmd = 1'b0;

    // R9 power-on beats everything, acts asynchronously
    porActive = 1'b1;
    extRstN   = 1'b0;
    wdtExpire = 1'b1;
    #1;
    chk("R9 por async", {14'd0, coreRst, coreRun}, 16'h2);
    chk("R9 por flags", {8'd0, statusView}, 16'h18);
    step();
    porActive = 1'b0;
    extRstN   = 1'b1;
    wdtExpire = 1'b0;
    step();
    step();
    chk("R9 hold", {15'd0, coreRst}, 16'h1);
    step();
    chk("R9 por cause wins", {13'd0, resetCause}, 16'h1);
    chk("R9 run again", {15'd0, coreRun}, 16'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule